// File: doc/BRIEF.md
# ADC Serial Port Slave

This block is the digital side of the serial port of an 8-channel, 12-bit successive-approximation converter. It runs entirely on the system clock. The serial clock, the active-low select and the data input are brought through synchronizers, and edges of the serial clock are detected in the system clock domain. Each frame lasts sixteen serial clock periods. During the first eight rising edges the block captures a control byte, MSB first. Over the whole frame it shifts a 16-bit word out on the data output. That word is four zeros followed by a 12-bit result, MSB first.

A parallel 12-bit input stands in for the analog core. The block samples that input at the instant it raises its hold strobe. For the whole conversion window it presents a channel select to the core. The channel is pipelined by one frame: the address written in a frame is applied when that frame ends, so the next frame converts it. At the same point the block also applies the power-mode and reference-disable fields and pulses a one-cycle valid strobe. If the select line stays low after sixteen clocks, the next frame starts at once. If the select line rises early, the partial frame is discarded.

Top module: `adc_port_slave`

## Requirements
- R1: After reset, dout_en, dout, hold and control_valid are 0, channel is 0 (the first input) and pm and ref_off are 0.
- R2: The control byte is taken from din on the first 8 rising serial clock edges of a frame, MSB first. Bits [5:3] are the channel address, bit 2 is ref_off and bits [1:0] are pm. Bits 7 and 6 have no effect on any output, and neither does din after the 8th rising edge.
- R3: dout_en is 1 exactly while the synchronized select is low. While dout_en is 0, dout is 0.
- R4: The output word is {4'b0000, result}. Bit 15 is presented once the select falls, and bit 15-k is presented after the k-th falling serial clock edge of the frame.
- R5: result_in is sampled at the 2nd rising edge of the frame. Later changes of result_in do not alter the word being shifted out.
- R6: hold is 1 from the 2nd rising edge until the 16th rising edge of a frame, and 0 otherwise.
- R7: During a frame, channel holds the address of the previous completed frame. The new address appears at the 16th rising edge.
- R8: pm and ref_off update at the 16th rising edge. control_valid is a single-cycle pulse, given once for each completed frame.
- R9: A frame whose select rises before the 16th rising edge changes neither channel, pm nor ref_off and gives no control_valid. The next select fall restarts the edge count at zero.
- R10: While the select stays low, the edge after the 16th rising edge starts a new frame, and bit 15 of the new word is presented after the 16th falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, asynchronous, idles low |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| din | input | 1 | Serial control data |
| result_in | input | 12 | Parallel conversion result from the core |
| dout | output | 1 | Serial result data |
| dout_en | output | 1 | Output drive enable; 0 models high impedance |
| hold | output | 1 | Track/hold strobe to the core |
| channel | output | 3 | Input select to the core (0 = first input) |
| pm | output | 2 | Applied power-mode field |
| ref_off | output | 1 | Applied internal-reference disable |
| control_valid | output | 1 | One-cycle pulse when a control word is applied |

## Verification
The bench uses the default two-stage synchronizer and a serial clock whose half period is eight system clocks. With these settings, every bit position of every frame can be sampled at a settled point just before the next rising edge. It sweeps all eight channel addresses and all power-mode codes, with results spread across the code range, including all-zeros and all-ones. It also runs an aborted frame, back-to-back frames under one select, and control bytes with the ignored bits set. With these cases the one-frame channel lag, the sampling instant and the wrap of the frame counters can each be observed at the ports.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
    localparam int RES_W     = 12;
    localparam int LEAD_W    = 4;
    localparam int WORD_W    = RES_W + LEAD_W;
    localparam int CTRL_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int PM_W      = 2;
    localparam int KEEP_W    = ADDR_W + 1 + PM_W;
    localparam int CNT_W     = $clog2(WORD_W);
    localparam int HOLD_RISE = 2;

    // Fields that survive capture; the two leading control bits fall off the top.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              ref_off;
        logic [PM_W-1:0]   pm;
    } ctrl_fields_t;

    function automatic logic [WORD_W-1:0] frame_word(input logic [RES_W-1:0] r);
        return {{LEAD_W{1'b0}}, r};
    endfunction

    function automatic logic [CNT_W-1:0] wrap_inc(input logic [CNT_W-1:0] c);
        return (c == CNT_W'(WORD_W - 1)) ? '0 : c + 1'b1;
    endfunction
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
    parameter int STAGES = 2,
    parameter bit INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= INIT;
                else     chain[g] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= INIT;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/adc_ctrl_shift.sv
module adc_ctrl_shift
    import adc_port_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output ctrl_fields_t fields
);
    logic [KEEP_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)           sh <= '0;
        else if (shift_en) sh <= {sh[KEEP_W-2:0], bit_in};
    end

    assign fields = ctrl_fields_t'(sh);
endmodule

// File: rtl/adc_out_seq.sv
module adc_out_seq
    import adc_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             load,
    input  logic             fall_evt,
    input  logic [RES_W-1:0] result_in,
    output logic             bit_out
);
    logic [RES_W-1:0]  res_q;
    logic [CNT_W-1:0]  fcnt;
    logic [WORD_W-1:0] word;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            fcnt  <= '0;
        end else begin
            if (load) res_q <= result_in;
            if (!active)       fcnt <= '0;
            else if (fall_evt) fcnt <= wrap_inc(fcnt);
        end
    end

    assign word    = frame_word(res_q);
    assign bit_out = word[CNT_W'(WORD_W - 1) - fcnt];
endmodule

// File: rtl/adc_port_slave.sv
module adc_port_slave
    import adc_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    input  logic [RES_W-1:0]  result_in,
    output logic              dout,
    output logic              dout_en,
    output logic              hold,
    output logic [ADDR_W-1:0] channel,
    output logic [PM_W-1:0]   pm,
    output logic              ref_off,
    output logic              control_valid
);
    localparam logic [CNT_W-1:0] CAP_LAST = CNT_W'(CTRL_W - 1);
    localparam logic [CNT_W-1:0] HOLD_AT  = CNT_W'(HOLD_RISE - 1);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(WORD_W - 1);

    logic cs_lvl, sclk_lvl, din_lvl, sclk_prev;
    logic active, s_rise, s_fall;
    logic shift_en, load, end_frame, out_bit;
    logic [CNT_W-1:0] rise_cnt;
    ctrl_fields_t fields;

    adc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .async_in(cs_n), .level(cs_lvl));
    adc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sclk_sync (
        .clk(clk), .rst(rst), .async_in(sclk), .level(sclk_lvl));
    adc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_din_sync (
        .clk(clk), .rst(rst), .async_in(din), .level(din_lvl));

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= sclk_lvl;
    end

    assign active    = ~cs_lvl;
    assign s_rise    = active & sclk_lvl & ~sclk_prev;
    assign s_fall    = active & ~sclk_lvl & sclk_prev;
    assign shift_en  = s_rise & (rise_cnt <= CAP_LAST);
    assign load      = s_rise & (rise_cnt == HOLD_AT);
    assign end_frame = s_rise & (rise_cnt == LAST);

    adc_ctrl_shift u_ctrl (
        .clk(clk), .rst(rst), .shift_en(shift_en), .bit_in(din_lvl), .fields(fields));

    adc_out_seq u_out (
        .clk(clk), .rst(rst), .active(active), .load(load), .fall_evt(s_fall),
        .result_in(result_in), .bit_out(out_bit));

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_cnt      <= '0;
            hold          <= 1'b0;
            channel       <= '0;
            pm            <= '0;
            ref_off       <= 1'b0;
            control_valid <= 1'b0;
        end else begin
            control_valid <= 1'b0;
            if (!active) begin
                rise_cnt <= '0;
                hold     <= 1'b0;
            end else if (s_rise) begin
                rise_cnt <= wrap_inc(rise_cnt);
                if (load) hold <= 1'b1;
                if (end_frame) begin
                    hold          <= 1'b0;
                    channel       <= fields.addr;
                    pm            <= fields.pm;
                    ref_off       <= fields.ref_off;
                    control_valid <= 1'b1;
                end
            end
        end
    end

    assign dout_en = active;
    assign dout    = active & out_bit;
endmodule

// File: rtl/adc_port_checks.sv
module adc_port_checks
    import adc_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dout,
    input logic              dout_en,
    input logic              hold,
    input logic [ADDR_W-1:0] channel,
    input logic [PM_W-1:0]   pm,
    input logic              ref_off,
    input logic              control_valid
);
    a_r6_hold_ends_with_commit: assert property (@(posedge clk) disable iff (rst)
        ($fell(hold) && dout_en) |-> control_valid);

    a_r7_channel_moves_on_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable(channel) |-> control_valid);

    a_r8_pm_moves_on_commit: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pm) || !$stable(ref_off)) |-> control_valid);

    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        control_valid |=> !control_valid);

    a_r4_lead_zero_at_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> !dout);

    a_r3_hold_needs_select: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> dout_en);
endmodule

bind adc_port_slave adc_port_checks u_checks (
    .clk(clk), .rst(rst), .dout(dout), .dout_en(dout_en), .hold(hold),
    .channel(channel), .pm(pm), .ref_off(ref_off), .control_valid(control_valid));

// File: tb/sim_adc_port_slave.sv
`timescale 1ns/1ps
module sim_adc_port_slave;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
    logic [11:0] result_in = '0;
    logic        dout, dout_en, hold, ref_off, control_valid;
    logic [2:0]  channel;
    logic [1:0]  pm;

    int n_run = 0, n_fail = 0, vcount = 0;
    bit finished = 0;
    logic [2:0] exp_ch = '0;
    logic [1:0] exp_pm = '0;
    logic       exp_ref = 1'b0;

    always #2.5 clk = ~clk;

    adc_port_slave u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
        .result_in(result_in), .dout(dout), .dout_en(dout_en), .hold(hold),
        .channel(channel), .pm(pm), .ref_off(ref_off), .control_valid(control_valid));

    always @(posedge clk) if (!rst && control_valid) vcount++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // One frame of n_rises rising edges with the select already low.
    task automatic run_frame(input logic [7:0] cw, input logic [11:0] res, input int n_rises);
        logic [15:0] word;
        int v0;
        word = {4'b0000, res};
        v0 = vcount;
        result_in = res;
        for (int i = 0; i < n_rises; i++) begin
            din = (i < 8) ? cw[7-i] : i[0];
            repeat (HALF) @(posedge clk);
            @(negedge clk);
            chk("R3 enable", dout_en, 1'b1);
            chk((i >= 4) ? "R5 data" : "R4 lead", dout, word[15-i]);
            chk("R6 hold", hold, (i >= 2));
            if (hold) chk("R7 lag", channel, exp_ch);
            sclk = 1'b1;
            repeat (HALF) @(posedge clk);
            if (i == 1) result_in = ~res;
            sclk = 1'b0;
        end
        repeat (HALF) @(posedge clk);
        @(negedge clk);
        if (n_rises == 16) begin
            exp_ch  = cw[5:3];
            exp_ref = cw[2];
            exp_pm  = cw[1:0];
            chk("R6 end", hold, 1'b0);
            chk("R8 pulse", vcount - v0, 1);
        end else begin
            chk("R9 no pulse", vcount - v0, 0);
        end
        chk("R7 channel", channel, exp_ch);
        chk("R2 pm", pm, exp_pm);
        chk("R2 ref", ref_off, exp_ref);
    endtask

    task automatic framed(input logic [7:0] cw, input logic [11:0] res, input int n_rises);
        cs_n = 1'b0;
        repeat (HALF) @(posedge clk);
        run_frame(cw, res, n_rises);
        cs_n = 1'b1;
        repeat (HALF) @(posedge clk);
        @(negedge clk);
        chk("R3 release", dout_en, 1'b0);
        chk("R3 quiet", dout, 1'b0);
        chk("R9 channel kept", channel, exp_ch);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 dout_en", dout_en, 0);
        chk("R1 dout", dout, 0);
        chk("R1 hold", hold, 0);
        chk("R1 channel", channel, 0);
        chk("R1 pm", pm, 0);
        chk("R1 ref", ref_off, 0);
        chk("R1 valid", control_valid, 0);

        // Sweep all addresses and power modes; ignored bits vary (R2).
        for (int a = 0; a < 8; a++) begin
            logic [7:0]  cw;
            logic [11:0] res;
            cw  = {a[0], a[1], a[2:0], a[2], a[1:0]};
            res = 12'(a * 12'h2A5 + 12'h013);
            framed(cw, res, 16);
        end
        framed(8'hC0, 12'hFFF, 16);  // R2: top bits set, address 0
        framed(8'h3F, 12'h000, 16);

        // R9: abort after 10 rises, then a clean frame restarting at zero.
        framed(8'hFF, 12'hA5A, 10);
        framed(8'h28, 12'h5A5, 16);

        // R10: two frames under one select.
        cs_n = 1'b0;
        repeat (HALF) @(posedge clk);
        run_frame(8'h11, 12'h9C3, 16);
        run_frame(8'h32, 12'h36C, 16);
        chk("R10 second frame", channel, 3'd6);
        cs_n = 1'b1;
        repeat (HALF) @(posedge clk);
        @(negedge clk);
        chk("R3 end", dout_en, 0);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end
endmodule